// File: doc/BRIEF.md
# HDLC Receive Frame Checker

This block sits behind a line deframer that has already removed flags and zero-bit stuffing. The deframer delivers frame content one byte at a time and separately signals each flag it sees and each abort sequence. The checker tracks where frames begin and end, counts the bytes of each frame, and compares that count with a programmable ceiling. It also runs a frame check sequence over every byte using either a 16-bit or a 32-bit reflected CRC. The preset and the expected good-frame residue are both configurable.

When a frame closes, the block reports the byte count and three status bits (CRC mismatch, over-length, aborted) and raises a one-cycle completion pulse. A single flag may close one frame and open the next. Completed frames are counted, and the interrupt output is raised only once that count reaches a programmable threshold. The interrupt stays high until software acknowledges it, and the acknowledge also clears the count.

Top module: `hdlc_rx_frame_check`

## Requirements
- R1: While `enable` is low, or after it is raised but before the first `in_flag`, received bytes and flags cause no completion pulse.
- R2: A single flag that follows frame bytes closes that frame and also opens the next one, so bytes after it form a new frame without any further flag.
- R3: `frame_len` gives the total number of bytes between the delimiting flags, counting the received check-sequence bytes.
- R4: `stat_too_long` is set exactly when the reported length is greater than `max_len`. A length equal to `max_len` is not flagged.
- R5: With `crc32_sel` low, the CRC uses the reflected polynomial 0x8408 and is preset from `crc_preset[15:0]`. Bytes enter LSB first. The frame is accepted when the final register equals `crc_residue[15:0]`, and the good-frame settings are preset 0xFFFF and residue 0xF0B8. Any other final value sets `stat_crc_err`.
- R6: With `crc32_sel` high, the CRC uses the reflected polynomial 0xEDB88320 with preset `crc_preset` and residue `crc_residue`. The good-frame settings are 0xFFFFFFFF and 0xDEBB20E3.
- R7: An `in_abort` during a frame that has at least one byte ends it with `stat_abort` set and `stat_crc_err` clear. After an abort, input is ignored until the next flag.
- R8: A frame shorter than ADDR_BYTES plus the check-sequence length (2 or 4 bytes) is dropped with no completion pulse.
- R9: `frame_done` is high for exactly one cycle per reported frame, in the cycle after the closing flag or abort is accepted. Flags with no bytes between them produce no pulse.
- R10: `irq` is high whenever the count of completed frames is nonzero and at least `frame_thresh`. A one-cycle `irq_ack` clears that count, so `irq` falls in the next cycle unless a new frame completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Receiver enable; low forces hunt state |
| crc32_sel | input | 1 | 1 selects 32-bit CRC, 0 selects 16-bit |
| crc_preset | input | 32 | CRC preset loaded at each opening flag |
| crc_residue | input | 32 | Expected final CRC value for a good frame |
| max_len | input | LEN_W | Largest permitted frame length in bytes |
| frame_thresh | input | CNT_W | Completed-frame count that raises the interrupt |
| irq_ack | input | 1 | Clears the completed-frame count |
| in_valid | input | 1 | A destuffed data byte is present |
| in_data | input | 8 | Data byte, bit 0 first on the line |
| in_flag | input | 1 | Flag detected |
| in_abort | input | 1 | Abort sequence detected |
| frame_done | output | 1 | One-cycle frame-completion pulse |
| frame_len | output | LEN_W | Length of the last reported frame |
| stat_crc_err | output | 1 | Last frame failed the residue check |
| stat_too_long | output | 1 | Last frame exceeded `max_len` |
| stat_abort | output | 1 | Last frame ended by abort |
| irq | output | 1 | Threshold-gated interrupt |

## Verification
Every result is registered once. The completion pulse, the length and the status bits appear in the cycle after the edge that accepts the closing flag or abort. The interrupt follows the frame count and so changes on that same edge. An acknowledge takes effect one edge after it is driven. The bench drives each input on a falling edge and reads the outputs on the next falling edge, which is exactly one rising edge later. For payload sweeps in both CRC widths, it computes the expected length, the over-length flag and the CRC result arithmetically from the bytes it sent.

// File: rtl/hdlc_rx_frame_check.sv
module hdlc_rx_frame_check #(
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 8,
  parameter int ADDR_BYTES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             crc32_sel,
  input  logic [31:0]      crc_preset,
  input  logic [31:0]      crc_residue,
  input  logic [LEN_W-1:0] max_len,
  input  logic [CNT_W-1:0] frame_thresh,
  input  logic             irq_ack,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_flag,
  input  logic             in_abort,
  output logic             frame_done,
  output logic [LEN_W-1:0] frame_len,
  output logic             stat_crc_err,
  output logic             stat_too_long,
  output logic             stat_abort,
  output logic             irq
);

  localparam logic [LEN_W-1:0] MIN16   = LEN_W'(ADDR_BYTES + 2);
  localparam logic [LEN_W-1:0] MIN32   = LEN_W'(ADDR_BYTES + 4);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             open_q;
  logic [LEN_W-1:0] len_q;
  logic [31:0]      crc_q;
  logic [CNT_W-1:0] fcnt_q;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d,
                                           input logic wide);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
      else             r = r >> 1;
    end
    return r;
  endfunction

  wire [31:0]      preset_m  = crc32_sel ? crc_preset  : {16'h0, crc_preset[15:0]};
  wire [31:0]      residue_m = crc32_sel ? crc_residue : {16'h0, crc_residue[15:0]};
  wire [LEN_W-1:0] min_len   = crc32_sel ? MIN32 : MIN16;
  wire             has_data  = len_q != '0;
  wire             end_abort = enable && open_q && in_abort && has_data;
  wire             end_flag  = enable && open_q && in_flag && !in_abort && has_data
                               && len_q >= min_len;
  wire             report    = end_abort || end_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      len_q  <= '0;
      crc_q  <= '0;
    end else if (!enable) begin
      open_q <= 1'b0;
      len_q  <= '0;
    end else if (in_abort) begin
      open_q <= 1'b0;
      len_q  <= '0;
    end else if (in_flag) begin
      open_q <= 1'b1;
      len_q  <= '0;
      crc_q  <= preset_m;
    end else if (in_valid && open_q) begin
      if (len_q != LEN_MAX) len_q <= len_q + 1'b1;
      crc_q <= crc_byte(crc_q, in_data, crc32_sel);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_done    <= 1'b0;
      frame_len     <= '0;
      stat_crc_err  <= 1'b0;
      stat_too_long <= 1'b0;
      stat_abort    <= 1'b0;
    end else begin
      frame_done <= report;
      if (report) begin
        frame_len     <= len_q;
        stat_abort    <= end_abort;
        stat_crc_err  <= end_flag && (crc_q != residue_m);
        stat_too_long <= len_q > max_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          fcnt_q <= '0;
    else if (irq_ack)                    fcnt_q <= report ? CNT_W'(1) : '0;
    else if (report && fcnt_q != CNT_MAX) fcnt_q <= fcnt_q + 1'b1;
  end

  assign irq = (fcnt_q != '0) && (fcnt_q >= frame_thresh);

endmodule

module hdlc_rx_frame_check_sva #(
  parameter int LEN_W      = 16,
  parameter int ADDR_BYTES = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             irq_ack,
  input logic [LEN_W-1:0] max_len,
  input logic             frame_done,
  input logic [LEN_W-1:0] frame_len,
  input logic             stat_crc_err,
  input logic             stat_too_long,
  input logic             stat_abort,
  input logic             irq
);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !frame_done);

  p_abort_no_crc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && stat_abort) |-> !stat_crc_err);

  p_short_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !stat_abort) |-> (frame_len >= LEN_W'(ADDR_BYTES + 2)));

  p_len_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && $stable(max_len)) |-> (stat_too_long == (frame_len > max_len)));

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!irq || frame_done));

endmodule

bind hdlc_rx_frame_check hdlc_rx_frame_check_sva #(.LEN_W(LEN_W), .ADDR_BYTES(ADDR_BYTES)) u_sva (
  .clk(clk), .rst_n(rst_n), .enable(enable), .irq_ack(irq_ack), .max_len(max_len),
  .frame_done(frame_done), .frame_len(frame_len), .stat_crc_err(stat_crc_err),
  .stat_too_long(stat_too_long), .stat_abort(stat_abort), .irq(irq)
);

// File: tb/hdlc_rx_frame_check_tb.sv
module hdlc_rx_frame_check_tb;
  localparam int LEN_W = 16;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, crc32_sel = 1'b0, irq_ack = 1'b0;
  logic [31:0] crc_preset = 32'h0000_FFFF, crc_residue = 32'h0000_F0B8;
  logic [LEN_W-1:0] max_len = 16'd10;
  logic [CNT_W-1:0] frame_thresh = '0;
  logic in_valid = 1'b0, in_flag = 1'b0, in_abort = 1'b0;
  logic [7:0] in_data = '0;
  logic frame_done, stat_crc_err, stat_too_long, stat_abort, irq;
  logic [LEN_W-1:0] frame_len;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  hdlc_rx_frame_check #(.LEN_W(LEN_W), .CNT_W(CNT_W), .ADDR_BYTES(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .crc32_sel(crc32_sel),
    .crc_preset(crc_preset), .crc_residue(crc_residue), .max_len(max_len),
    .frame_thresh(frame_thresh), .irq_ack(irq_ack), .in_valid(in_valid),
    .in_data(in_data), .in_flag(in_flag), .in_abort(in_abort),
    .frame_done(frame_done), .frame_len(frame_len), .stat_crc_err(stat_crc_err),
    .stat_too_long(stat_too_long), .stat_abort(stat_abort), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d,
                                          input logic wide);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
    end
    return r;
  endfunction

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_flag = 1'b0; in_abort = 1'b0;
  endtask

  // flag, then sample one rising edge later
  task automatic put_flag();
    @(negedge clk);
    in_valid = 1'b0; in_flag = 1'b1; in_abort = 1'b0;
    @(negedge clk);
    in_flag = 1'b0;
  endtask

  task automatic put_abort();
    @(negedge clk);
    in_valid = 1'b0; in_flag = 1'b0; in_abort = 1'b1;
    @(negedge clk);
    in_abort = 1'b0;
  endtask

  // payload of p bytes plus FCS, optional corruption, then closing flag and checks
  task automatic send_frame(input int p, input logic wide, input logic bad, input string tag);
    logic [31:0] c;
    logic [7:0] b;
    int fl, total;
    c  = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    fl = wide ? 4 : 2;
    for (int i = 0; i < p; i++) c = ref_crc(c, 8'((i * 37 + p * 11 + 5) & 255), wide);
    c = ~c;
    for (int i = 0; i < p; i++) begin
      b = 8'((i * 37 + p * 11 + 5) & 255);
      if (bad && i == 0) b = b ^ 8'h01;
      put_byte(b);
    end
    for (int k = 0; k < fl; k++) put_byte(c[8*k +: 8]);
    put_flag();
    total = p + fl;
    if (total < 1 + fl) begin
      chk({tag, " R8 short dropped"}, frame_done, 0);
    end else begin
      chk({tag, " R9 done"}, frame_done, 1);
      chk({tag, " R3 length"}, frame_len, total);
      chk({tag, wide ? " R6 crc32" : " R5 crc16"}, stat_crc_err, bad);
      chk({tag, " R4 too long"}, stat_too_long, total > int'(max_len));
      chk({tag, " R7 no abort"}, stat_abort, 0);
      @(negedge clk);
      chk({tag, " R9 single pulse"}, frame_done, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset done", frame_done, 0);
    chk("reset len", frame_len, 0);
    chk("R10 reset irq", irq, 0);

    // R1: disabled, then enabled before any flag
    put_flag(); put_byte(8'h11); put_byte(8'h22); put_byte(8'h33); put_flag();
    chk("R1 disabled", frame_done, 0);
    enable = 1'b1;
    put_byte(8'hA5); put_byte(8'h5A); put_byte(8'h3C); put_byte(8'hC3);
    put_flag();
    chk("R1 hunt for flag", frame_done, 0);

    // R5 sweep, shared flags R2
    max_len = 16'd10;
    for (int p = 0; p <= 12; p++) send_frame(p, 1'b0, 1'b0, "c16 good");
    for (int p = 1; p <= 10; p++) send_frame(p, 1'b0, 1'b1, "c16 bad");

    // R9: repeated idle flags give no event
    put_flag(); chk("R9 idle flag", frame_done, 0);
    put_flag(); chk("R9 idle flag", frame_done, 0);

    // R6 sweep
    crc32_sel = 1'b1; crc_preset = 32'hFFFF_FFFF; crc_residue = 32'hDEBB_20E3;
    max_len = 16'd12;
    put_flag(); chk("R2 reopen in crc32", frame_done, 0);
    for (int p = 0; p <= 12; p++) send_frame(p, 1'b1, 1'b0, "c32 good");
    for (int p = 1; p <= 10; p++) send_frame(p, 1'b1, 1'b1, "c32 bad");

    // R7 abort
    put_byte(8'h01); put_byte(8'h02); put_byte(8'h03); put_byte(8'h04);
    put_abort();
    chk("R7 abort done", frame_done, 1);
    chk("R7 abort status", stat_abort, 1);
    chk("R7 abort crc", stat_crc_err, 0);
    chk("R7 abort len", frame_len, 4);
    for (int i = 0; i < 8; i++) put_byte(8'(i));
    put_flag();
    chk("R7 ignored after abort", frame_done, 0);
    send_frame(3, 1'b1, 1'b0, "R7 recover");

    // R10 threshold and ack
    crc32_sel = 1'b0; crc_preset = 32'h0000_FFFF; crc_residue = 32'h0000_F0B8;
    max_len = 16'd10;
    put_flag();
    frame_thresh = 8'd3;
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R10 ack clears", irq, 0);
    send_frame(2, 1'b0, 1'b0, "irq1"); chk("R10 below thresh 1", irq, 0);
    send_frame(3, 1'b0, 1'b0, "irq2"); chk("R10 below thresh 2", irq, 0);
    send_frame(4, 1'b0, 1'b0, "irq3"); chk("R10 at thresh", irq, 1);
    send_frame(5, 1'b0, 1'b0, "irq4"); chk("R10 above thresh", irq, 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R10 ack drops irq", irq, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule